// File: doc/BRIEF.md
# Four-Step One-Hot Light Chaser

This block is a small synchronous sequence generator that drives three lamp outputs. Its normal loop has four steps: all lamps dark, then the lowest lamp lit alone, then the middle lamp alone, then the top lamp alone, and then dark again. All state bits sit on one clock. The state moves forward only on a clock edge where the step-enable tick is high, so a slow pacing tick from elsewhere in the chip sets the chase rate.

The register can wake up holding any of its eight codes. The next-state logic gives every code outside the loop a route back into it: the top bit takes the middle bit, the middle bit takes the low bit, and the low bit is set only when all bits are clear. So no state can stay outside the loop. A synchronous active-low reset forces the dark step. A preload port writes any code straight into the register so that the recovery routes can be exercised. A flag output shows whether the present code belongs to the loop.

Top module: `chaser_seq`

## Requirements
- R1: On a clock edge with rst_n low, lamp_o becomes 000. Reset takes priority over load_en and step_en.
- R2: On an edge with rst_n high, load_en low and step_en low, lamp_o keeps its value.
- R3: With step_en high, the loop codes (bit 2 = C, bit 1 = B, bit 0 = A) advance 000 → 001 → 010 → 100 → 000.
- R4: With step_en high, the unused codes advance 011 → 110, 101 → 010, 110 → 100 and 111 → 110.
- R5: From any of the eight codes, at most two enabled steps bring lamp_o into the loop, and it never leaves the loop after that.
- R6: in_main is high exactly when lamp_o is 000, 001, 010 or 100, in the same cycle.
- R7: On an edge with rst_n high and load_en high, lamp_o takes load_val whatever step_en is.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by all state bits |
| rst_n | input | 1 | Synchronous reset, active low, forces 000 |
| step_en | input | 1 | Advance tick; the state moves only when high |
| load_en | input | 1 | Preload strobe, above step_en, below reset |
| load_val | input | 3 | Code written on a preload edge |
| lamp_o | output | 3 | Current state; bit 2 = C, bit 1 = B, bit 0 = A; 1 = lit |
| in_main | output | 1 | High while lamp_o is one of the four loop codes |

## Verification
The assertions assume that rst_n is held low for at least one edge before any check counts, since before that the register holds an unknown code. They also assume that load_en and step_en are sampled only at clock edges, and that a preload can put any code, including an unused one, into the register. The stimulus drives all inputs half a cycle away from the edge. It applies reset first. It then preloads each of the eight codes and follows each with enabled and idle steps, and it mixes reset and preload with step_en to exercise the priority order.

// File: rtl/chaser_pkg.sv
// Package: shared width and type for the light chaser.
// Assumes the lamp vector is ordered with the top lamp in the MSB.
package chaser_pkg;
    localparam int unsigned LAMP_W = 3;
    typedef logic [LAMP_W-1:0] lamp_t;
endpackage

// File: rtl/chaser_next.sv
// chaser_next: combinational next-state function of the chaser.
// Each bit takes the bit below it, and bit 0 is set only when every bit is clear.
// Assumes W >= 2. Every code drains into the one-hot walk within W-1 steps.
module chaser_next #(
    parameter int unsigned W = 3
) (
    input  logic [W-1:0] cur_i,
    output logic [W-1:0] nxt_o
);
    // Upper bits: shift the pattern up by one position.
    for (genvar g = 1; g < W; g++) begin : g_shift
        assign nxt_o[g] = cur_i[g-1];
    end

    // Bit 0: reload a lamp only after the pattern has fully drained.
    assign nxt_o[0] = ~(|cur_i);
endmodule

// File: rtl/chaser_reg.sv
// chaser_reg: state register with the priority reset > preload > step > hold.
// Assumes all controls are synchronous to clk. Reset is active low.
module chaser_reg #(
    parameter int unsigned W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step_en,
    input  logic         load_en,
    input  logic [W-1:0] load_val,
    input  logic [W-1:0] nxt_i,
    output logic [W-1:0] state_q
);
    // Update the state on each edge according to the priority order.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else if (load_en) begin
            state_q <= load_val;
        end else if (step_en) begin
            state_q <= nxt_i;
        end
    end
endmodule

// File: rtl/chaser_loop_detect.sv
// chaser_loop_detect: flags codes that belong to the main loop.
// The loop codes are all-zero or a single set bit. Purely combinational.
module chaser_loop_detect #(
    parameter int unsigned W = 3
) (
    input  logic [W-1:0] state_i,
    output logic         in_loop_o
);
    logic [W-1:0] dec;

    // Clearing the lowest set bit leaves zero only for at most one set bit.
    always_comb begin
        dec       = state_i - W'(1);
        in_loop_o = ((state_i & dec) == '0);
    end
endmodule

// File: rtl/chaser_seq.sv
// chaser_seq: top level of the four-step light chaser.
// Connects the next-state function, the state register and the loop flag.
// Assumes step_en is a single-cycle pacing tick from the surrounding logic.
module chaser_seq
    import chaser_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        step_en,
    input  logic        load_en,
    input  logic [2:0]  load_val,
    output logic [2:0]  lamp_o,
    output logic        in_main
);
    lamp_t state_q;
    lamp_t nxt;

    chaser_next #(.W(LAMP_W)) u_next (
        .cur_i (state_q),
        .nxt_o (nxt)
    );

    chaser_reg #(.W(LAMP_W)) u_reg (
        .clk      (clk),
        .rst_n    (rst_n),
        .step_en  (step_en),
        .load_en  (load_en),
        .load_val (load_val),
        .nxt_i    (nxt),
        .state_q  (state_q)
    );

    chaser_loop_detect #(.W(LAMP_W)) u_loop (
        .state_i   (state_q),
        .in_loop_o (in_main)
    );

    assign lamp_o = state_q;
endmodule

// File: rtl/chaser_seq_chk.sv
// chaser_seq_chk: property checker for chaser_seq, attached through bind.
// Checks start only after the first reset edge has been seen.
module chaser_seq_chk #(
    parameter int unsigned W = 3
) (
    input logic         clk,
    input logic         rst_n,
    input logic         step_en,
    input logic         load_en,
    input logic [W-1:0] load_val,
    input logic [W-1:0] lamp_o,
    input logic         in_main
);
    localparam int unsigned CW = $clog2(W) + 1;

    logic          seen_rst;
    logic [CW-1:0] out_steps;

    // Record that reset has been applied at least once.
    always_ff @(posedge clk) begin
        if (!rst_n) seen_rst <= 1'b1;
        else if (seen_rst !== 1'b1) seen_rst <= 1'b0;
    end

    // Count the enabled steps taken while outside the loop.
    always_ff @(posedge clk) begin
        if (!rst_n || load_en) out_steps <= '0;
        else if (step_en) out_steps <= in_main ? '0 : out_steps + CW'(1);
    end

    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (seen_rst !== 1'b1)
        !rst_n |=> (lamp_o == '0)); // R1

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n || seen_rst !== 1'b1)
        (!load_en && !step_en) |=> $stable(lamp_o)); // R2

    AST_LOOP_CLOSED: assert property (@(posedge clk) disable iff (!rst_n || seen_rst !== 1'b1)
        (in_main && step_en && !load_en) |=> in_main); // R3

    AST_ESCAPE_NO_RELOAD: assert property (@(posedge clk) disable iff (!rst_n || seen_rst !== 1'b1)
        (!in_main && step_en && !load_en) |=> (lamp_o[0] == 1'b0)); // R4

    AST_CONVERGE_BOUND: assert property (@(posedge clk) disable iff (!rst_n || seen_rst !== 1'b1)
        out_steps <= CW'(W-1)); // R5

    AST_FLAG_MATCH: assert property (@(posedge clk) disable iff (!rst_n || seen_rst !== 1'b1)
        in_main == $onehot0(lamp_o)); // R6

    AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n || seen_rst !== 1'b1)
        load_en |=> (lamp_o == $past(load_val))); // R7
endmodule

bind chaser_seq chaser_seq_chk #(.W(3)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .step_en  (step_en),
    .load_en  (load_en),
    .load_val (load_val),
    .lamp_o   (lamp_o),
    .in_main  (in_main)
);

// File: tb/test_chaser_seq.sv
// Scoreboard bench for chaser_seq: the driver pushes expected results,
// and the monitor pops and compares them at each falling edge.
module test_chaser_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b1;
    logic       step_en = 1'b0;
    logic       load_en = 1'b0;
    logic [2:0] load_val = 3'b000;
    logic [2:0] lamp_o;
    logic       in_main;

    int checks = 0;
    int failures = 0;

    typedef struct {
        logic [2:0] lamp;
        logic       flag;
        string      tag;
    } exp_t;

    exp_t       sb_q[$];
    logic [2:0] model = 3'b000;

    always #2.5 clk = ~clk;

    chaser_seq i_chaser_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .step_en  (step_en),
        .load_en  (load_en),
        .load_val (load_val),
        .lamp_o   (lamp_o),
        .in_main  (in_main)
    );

    // Reference successor, taken from the transition lists of R3 and R4.
    function automatic logic [2:0] succ(input logic [2:0] s);
        case (s)
            3'b000: return 3'b001;
            3'b001: return 3'b010;
            3'b010: return 3'b100;
            3'b100: return 3'b000;
            3'b011: return 3'b110;
            3'b101: return 3'b010;
            3'b110: return 3'b100;
            default: return 3'b110;
        endcase
    endfunction

    function automatic logic loop_code(input logic [2:0] s);
        return (s == 3'b000) || (s == 3'b001) || (s == 3'b010) || (s == 3'b100);
    endfunction

    // Driver: apply one cycle of inputs and queue the expected result.
    task automatic drive(input logic r, input logic ld, input logic [2:0] v,
                         input logic st, input string tag);
        exp_t e;
        @(negedge clk);
        rst_n = r; load_en = ld; load_val = v; step_en = st;
        if (!r) model = 3'b000;
        else if (ld) model = v;
        else if (st) model = succ(model);
        e.lamp = model; e.flag = loop_code(model); e.tag = tag;
        @(posedge clk);
        #1 sb_q.push_back(e);
    endtask

    // Monitor: compare outputs against the oldest queued expectation.
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            checks++;
            if (lamp_o !== e.lamp || in_main !== e.flag) begin
                failures++;
                $display("FAIL %s: lamp=%b in_main=%b expected lamp=%b in_main=%b",
                         e.tag, lamp_o, in_main, e.lamp, e.flag);
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R1: reset with load and step also high still clears.
        drive(1'b0, 1'b1, 3'b111, 1'b1, "R1 reset priority");
        drive(1'b0, 1'b0, 3'b000, 1'b0, "R1 reset state");
        // R3: two full turns of the loop.
        for (int i = 0; i < 8; i++) drive(1'b1, 1'b0, 3'b000, 1'b1, "R3 loop step");
        // R2: idle cycles hold in the middle of the loop.
        drive(1'b1, 1'b0, 3'b000, 1'b1, "R3 loop step");
        for (int i = 0; i < 3; i++) drive(1'b1, 1'b0, 3'b101, 1'b0, "R2 hold");
        // R7: load beats step.
        drive(1'b1, 1'b1, 3'b011, 1'b1, "R7 load over step");
        drive(1'b1, 1'b0, 3'b000, 1'b0, "R2 hold unused");
        // R4 and R5: start from every code and check entry within two steps.
        for (int s = 0; s < 8; s++) begin
            drive(1'b1, 1'b1, 3'(s), 1'b0, "R7 preload");
            drive(1'b1, 1'b0, 3'b000, 1'b1, loop_code(3'(s)) ? "R3 step" : "R4 escape");
            drive(1'b1, 1'b0, 3'b000, 1'b1, "R5 within two steps");
            checks++;
            if (!loop_code(model)) begin
                failures++;
                $display("FAIL R5: model code %b after two steps, expected loop code", model);
            end
            for (int k = 0; k < 4; k++) drive(1'b1, 1'b0, 3'b000, 1'b1, "R5 stays in loop");
        end
        // R6: flag follows unused codes held idle.
        drive(1'b1, 1'b1, 3'b111, 1'b0, "R6 flag unused");
        drive(1'b1, 1'b0, 3'b000, 1'b0, "R6 flag held");
        // R1: reset from an unused code.
        drive(1'b0, 1'b0, 3'b000, 1'b1, "R1 reset from unused");
        drive(1'b1, 1'b0, 3'b000, 1'b0, "R2 hold after reset");
        @(negedge clk);
        @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule